// File: doc/BRIEF.md
# Microcoded Immediate-Add Sequencer

This block is the control and datapath slice of a small execution unit. It takes instruction bytes from a byte-wide prefetch queue using a valid/ready handshake. It runs a short micro-program held in an internal ROM to execute the 16-bit add-immediate-to-accumulator instruction. The block contains a small register file, of which entry 0 is the accumulator. It also holds a temporary operand register, an ALU input latch, a 16-bit ALU and a six-bit flags register.

Each micro-word describes one transfer on an internal bus, given as a source and a destination, plus a separate action. The micro-word only says "the register" and "the ALU operation". Opcode decode logic binds those to a real register index and a real ALU function when the opcode is accepted. The next opcode is accepted during the write-back step of the current instruction. A continuous instruction stream therefore retires one add every four clocks, even though each add spans five cycles of activity from opcode decode to write-back.

Top module: `ucode_add_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the block enters an idle state. After that edge, the accumulator and all flags read 0, `done` is 0 and `q_ready` is 1.
- R2: Opcode byte 0x05 starts a three-byte instruction. The next queue byte is bits 7:0 of the immediate and the byte after it is bits 15:8. On completion, `acc_out` becomes (previous accumulator + immediate) mod 2^16.
- R3: Any opcode byte other than 0x05 is taken from the queue as a single byte. It changes neither `acc_out` nor `flags_out` and raises no `done`, and the following byte is again treated as an opcode.
- R4: The add runs as four micro-steps: low byte, high byte, accumulator to ALU input, then write-back. `q_ready` is 0 during the third step, and the clock after the high byte is accepted shows `done` = 0.
- R5: With queue bytes always available, `done` is high for exactly one cycle. That cycle is the second one after the edge that accepts the high immediate byte. The new `acc_out` and `flags_out` are visible in the following cycle.
- R6: `q_ready` is high in the write-back cycle so that the next opcode is decoded in overlap. A continuous stream of adds gives `done` pulses exactly four cycles apart.
- R7: When a byte step finds `q_valid` low, the sequencer waits on that step with all state held. `q_ready` stays 1, `done` stays 0, and the final result is the same as without the wait.
- R8: `flags_out` bit 0 is carry out of bit 15 and bit 1 is even parity of result bits 7:0. Bit 2 is carry out of bit 3, bit 3 is zero result, bit 4 is result bit 15, and bit 5 is signed overflow.
- R9: `acc_out` and `flags_out` change only in the cycle after a `done` pulse (or by reset).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| q_data | input | 8 | Instruction byte from the prefetch queue |
| q_valid | input | 1 | Queue byte is present |
| q_ready | output | 1 | Sequencer takes the byte at this edge when `q_valid` is high |
| acc_out | output | 16 | Accumulator contents |
| flags_out | output | 6 | Flags {overflow, sign, zero, aux carry, parity, carry} |
| done | output | 1 | High in the write-back cycle of an add |

## Verification
The add is driven with a grid of corner operand pairs. Each pair is reached by first steering the accumulator to a chosen value. The grid covers zero, one, nibble and byte boundaries, 0x7FFF, 0x8000 and 0xFFFF, so that carry, auxiliary carry, overflow, sign, zero and parity are each set and cleared both alone and together. A pseudo-random stream follows and checks the arithmetic away from the corners. The grid and the random stream both run back to back, which tests the four-cycle retire spacing. Separate patterns insert gaps in the byte flow to tell a correct stall from a skipped or repeated step. Non-add opcode bytes are mixed in to check that they are consumed singly and leave the state untouched.

// File: rtl/useq_pkg.sv
package useq_pkg;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 16;
    localparam int NFLAG  = 6;
    localparam int USTEPS = 4;
    localparam int UPC_W  = $clog2(USTEPS);

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {BS_QUEUE, BS_REG, BS_TMP, BS_ALU} bus_src_t;
    typedef enum logic [1:0] {BD_TMP_LO, BD_TMP_HI, BD_ALU_A, BD_REG} bus_dst_t;
    typedef enum logic [1:0] {AC_NEXT, AC_ALU_GO, AC_WB_END, AC_NOP} uact_t;
    typedef enum logic [1:0] {FN_ADD, FN_PASS_B, FN_NONE} alu_fn_t;

    typedef struct packed {
        bus_src_t src;
        bus_dst_t dst;
        uact_t    act;
    } uword_t;

    // bit 5..0 = overflow, sign, zero, aux carry, parity, carry
    typedef struct packed {
        logic ovf;
        logic sgn;
        logic zro;
        logic aux;
        logic par;
        logic cry;
    } flags_t;

    typedef struct packed {
        word_t  sum;
        flags_t fl;
    } alu_out_t;

    function automatic uword_t urom_word(input logic [UPC_W-1:0] a);
        uword_t w;
        case (a)
            2'd0:    w = '{src: BS_QUEUE, dst: BD_TMP_LO, act: AC_NEXT};
            2'd1:    w = '{src: BS_QUEUE, dst: BD_TMP_HI, act: AC_NEXT};
            2'd2:    w = '{src: BS_REG,   dst: BD_ALU_A,  act: AC_ALU_GO};
            default: w = '{src: BS_ALU,   dst: BD_REG,    act: AC_WB_END};
        endcase
        return w;
    endfunction
endpackage

// File: rtl/useq_rom.sv
module useq_rom
    import useq_pkg::*;
(
    input  logic [UPC_W-1:0] upc,
    output uword_t           uword
);
    always_comb uword = urom_word(upc);
endmodule

// File: rtl/useq_decode.sv
module useq_decode
    import useq_pkg::*;
#(
    parameter logic [BYTE_W-1:0] OPC_ADD_IMM = 8'h05,
    parameter int RIDX_W  = 2,
    parameter int ACC_IDX = 0
) (
    input  logic [BYTE_W-1:0] opcode,
    output logic              is_exec,
    output alu_fn_t           fn,
    output logic [RIDX_W-1:0] ridx
);
    always_comb begin
        is_exec = 1'b0;
        fn      = FN_NONE;
        ridx    = '0;
        if (opcode == OPC_ADD_IMM) begin
            is_exec = 1'b1;
            fn      = FN_ADD;
            ridx    = RIDX_W'(ACC_IDX);
        end
    end
endmodule

// File: rtl/useq_alu.sv
module useq_alu
    import useq_pkg::*;
(
    input  alu_fn_t  fn,
    input  word_t    a,
    input  word_t    b,
    output alu_out_t res
);
    logic [WORD_W:0] wide;
    logic            cin_msb;

    always_comb begin
        wide    = '0;
        cin_msb = 1'b0;
        case (fn)
            FN_ADD: begin
                wide    = {1'b0, a} + {1'b0, b};
                cin_msb = a[WORD_W-1] ^ b[WORD_W-1] ^ wide[WORD_W-1];
            end
            FN_PASS_B: wide = {1'b0, b};
            default:   wide = {1'b0, a};
        endcase
        res.sum    = wide[WORD_W-1:0];
        res.fl.cry = wide[WORD_W];
        res.fl.ovf = cin_msb ^ wide[WORD_W];
        res.fl.aux = (fn == FN_ADD) ? (a[4] ^ b[4] ^ wide[4]) : 1'b0;
        res.fl.zro = (wide[WORD_W-1:0] == '0);
        res.fl.sgn = wide[WORD_W-1];
        res.fl.par = ~^wide[BYTE_W-1:0];
    end
endmodule

// File: rtl/ucode_add_seq.sv
module ucode_add_seq
    import useq_pkg::*;
#(
    parameter logic [BYTE_W-1:0] OPC_ADD_IMM = 8'h05,
    parameter int NREG    = 4,
    parameter int ACC_IDX = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BYTE_W-1:0] q_data,
    input  logic              q_valid,
    output logic              q_ready,
    output logic [WORD_W-1:0] acc_out,
    output logic [NFLAG-1:0]  flags_out,
    output logic              done
);
    localparam int RIDX_W = (NREG > 1) ? $clog2(NREG) : 1;

    logic              running;
    logic [UPC_W-1:0]  upc;
    word_t             tmp;
    word_t             alu_a;
    word_t             regs [NREG];
    flags_t            flg;
    alu_fn_t           fn_pend;
    alu_fn_t           alu_op;
    logic [RIDX_W-1:0] ridx_q;

    uword_t            uw;
    logic              dec_ok;
    alu_fn_t           dec_fn;
    logic [RIDX_W-1:0] dec_ridx;
    alu_out_t          alu_res;
    word_t             bus;
    logic              opc_slot;
    logic              step_go;
    logic              start;

    useq_rom u_rom (.upc(upc), .uword(uw));

    useq_decode #(.OPC_ADD_IMM(OPC_ADD_IMM), .RIDX_W(RIDX_W), .ACC_IDX(ACC_IDX)) u_dec (
        .opcode(q_data), .is_exec(dec_ok), .fn(dec_fn), .ridx(dec_ridx)
    );

    useq_alu u_alu (.fn(alu_op), .a(alu_a), .b(tmp), .res(alu_res));

    // Opcode decode slot: idle, or overlapped with write-back
    assign opc_slot = !running || (uw.act == AC_WB_END);
    assign q_ready  = opc_slot || (running && uw.src == BS_QUEUE);
    assign start    = opc_slot && q_valid && dec_ok;
    assign step_go  = running && ((uw.src != BS_QUEUE) || q_valid);
    assign done     = running && (uw.act == AC_WB_END);

    always_comb begin
        case (uw.src)
            BS_QUEUE: bus = {{(WORD_W-BYTE_W){1'b0}}, q_data};
            BS_REG:   bus = regs[ridx_q];
            BS_TMP:   bus = tmp;
            default:  bus = alu_res.sum;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            running <= 1'b0;
            upc     <= '0;
            tmp     <= '0;
            alu_a   <= '0;
            flg     <= '0;
            fn_pend <= FN_NONE;
            alu_op  <= FN_NONE;
            ridx_q  <= '0;
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else begin
            if (step_go) begin
                case (uw.dst)
                    BD_TMP_LO: tmp[BYTE_W-1:0]        <= bus[BYTE_W-1:0];
                    BD_TMP_HI: tmp[WORD_W-1:BYTE_W]   <= bus[BYTE_W-1:0];
                    BD_ALU_A:  alu_a                  <= bus;
                    default:   regs[ridx_q]           <= bus;
                endcase
                case (uw.act)
                    AC_ALU_GO: alu_op <= fn_pend;
                    AC_WB_END: flg    <= alu_res.fl;
                    default: ;
                endcase
                if (uw.act == AC_WB_END) begin
                    running <= start;
                    upc     <= '0;
                end else begin
                    upc <= upc + 1'b1;
                end
            end else if (!running && start) begin
                running <= 1'b1;
                upc     <= '0;
            end
            if (start) begin
                fn_pend <= dec_fn;
                ridx_q  <= dec_ridx;
            end
        end
    end

    assign acc_out   = regs[ACC_IDX];
    assign flags_out = flg;
endmodule

// File: rtl/ucode_add_seq_chk.sv
module ucode_add_seq_chk
    import useq_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              q_ready,
    input logic [WORD_W-1:0] acc_out,
    input logic [NFLAG-1:0]  flags_out,
    input logic              done
);
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (acc_out == '0 && flags_out == '0 && !done && q_ready));

    a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r6_overlap_ready: assert property (@(posedge clk) disable iff (rst)
        done |-> q_ready);

    a_r8_result_flags: assert property (@(posedge clk) disable iff (rst)
        done |=> (flags_out[3] == (acc_out == '0)) && (flags_out[4] == acc_out[WORD_W-1])
                 && (flags_out[1] == ~^acc_out[7:0]));

    a_r9_hold_between: assert property (@(posedge clk) disable iff (rst)
        !done |=> ($stable(acc_out) && $stable(flags_out)));
endmodule

bind ucode_add_seq ucode_add_seq_chk u_chk (
    .clk(clk), .rst(rst), .q_ready(q_ready),
    .acc_out(acc_out), .flags_out(flags_out), .done(done)
);

// File: tb/sim_ucode_add_seq.sv
module sim_ucode_add_seq;
    localparam int CLK_PERIOD = 10;
    localparam int EXPN = 1024;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  q_data = 8'h00;
    logic        q_valid = 1'b0;
    logic        q_ready;
    logic [15:0] acc_out;
    logic [5:0]  flags_out;
    logic        done;

    int checks = 0;
    int fails  = 0;

    logic [15:0] m_acc = 16'h0;
    logic [15:0] exp_acc [EXPN];
    logic [5:0]  exp_flg [EXPN];
    int wr = 0;
    int rd = 0;
    int retires = 0;
    int cyc = 0;
    int last_ret = 0;
    bit have_last = 0;
    bit chk_int = 0;
    bit pend = 0;
    bit finished = 0;

    ucode_add_seq u0 (
        .clk(clk), .rst(rst), .q_data(q_data), .q_valid(q_valid), .q_ready(q_ready),
        .acc_out(acc_out), .flags_out(flags_out), .done(done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [5:0] ref_flags(input logic [15:0] a, input logic [15:0] b);
        logic [16:0] s;
        logic [15:0] r;
        logic cf, pf, af, zf, sf, of;
        s  = {1'b0, a} + {1'b0, b};
        r  = s[15:0];
        cf = s[16];
        pf = ~^r[7:0];
        af = ({1'b0, a[3:0]} + {1'b0, b[3:0]}) > 5'd15;
        zf = (r == 16'h0);
        sf = r[15];
        of = (a[15] == b[15]) && (r[15] != a[15]);
        return {of, sf, zf, af, pf, cf};
    endfunction

    task automatic expect_add(input logic [15:0] imm);
        exp_flg[wr] = ref_flags(m_acc, imm);
        m_acc       = m_acc + imm;
        exp_acc[wr] = m_acc;
        wr++;
    endtask

    task automatic push(input logic [7:0] b);
        @(negedge clk);
        q_valid = 1'b1;
        q_data  = b;
        #1;
        while (!q_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        #1 q_valid = 1'b0;
    endtask

    task automatic push_add(input logic [15:0] imm);
        expect_add(imm);
        push(8'h05);
        push(imm[7:0]);
        push(imm[15:8]);
    endtask

    // Retire monitor: compare the cycle after each done pulse (R2, R8, R6)
    always @(negedge clk) begin
        if (!finished) begin
            if (pend) begin
                if (rd < wr) begin
                    check(acc_out == exp_acc[rd], "R2 sum", {16'h0, acc_out}, {16'h0, exp_acc[rd]});
                    check(flags_out == exp_flg[rd], "R8 flags", {26'h0, flags_out}, {26'h0, exp_flg[rd]});
                    rd++;
                end else begin
                    check(1'b0, "R3 unexpected retire", 32'(retires), 32'(wr));
                end
            end
            pend = done && !rst;
            if (done && !rst) begin
                retires++;
                if (chk_int && have_last)
                    check(cyc - last_ret == 4, "R6 spacing", 32'(cyc - last_ret), 32'd4);
                last_ret  = cyc;
                have_last = 1'b1;
            end
        end
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin : stim
        logic [15:0] corner [12];
        logic [31:0] lcg;
        logic [15:0] acc_snap;
        logic [5:0]  flg_snap;
        int          ret_snap;
        corner = '{16'h0000, 16'h0001, 16'h000F, 16'h0008, 16'h0080, 16'h00FF,
                   16'h0F0F, 16'h7FFF, 16'h8000, 16'h8001, 16'hFFFF, 16'h1234};

        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check(acc_out == 16'h0, "R1 acc", {16'h0, acc_out}, 32'h0);
        check(flags_out == 6'h0, "R1 flags", {26'h0, flags_out}, 32'h0);
        check(!done && q_ready, "R1 idle", {30'h0, done, q_ready}, 32'h1);

        // R4 / R5: step timing from the high-byte acceptance
        push_add(16'h1234);
        @(negedge clk);
        check(!done && !q_ready, "R4 alu step", {30'h0, done, q_ready}, 32'h0);
        @(negedge clk);
        check(done == 1'b1, "R5 done cycle", {31'h0, done}, 32'h1);
        check(acc_out == 16'h0, "R5 acc before wb", {16'h0, acc_out}, 32'h0);
        @(negedge clk);
        check(acc_out == 16'h1234, "R5 acc after wb", {16'h0, acc_out}, 32'h1234);
        repeat (3) @(negedge clk);

        // R3: unsupported opcodes consumed singly, no effect
        acc_snap = acc_out;
        flg_snap = flags_out;
        ret_snap = retires;
        push(8'h04);
        push(8'h90);
        push(8'hFF);
        repeat (6) @(negedge clk);
        check(acc_out == acc_snap, "R3 acc kept", {16'h0, acc_out}, {16'h0, acc_snap});
        check(flags_out == flg_snap, "R3 flags kept", {26'h0, flags_out}, {26'h0, flg_snap});
        check(retires == ret_snap, "R3 no retire", 32'(retires), 32'(ret_snap));
        push_add(16'h0001);
        repeat (6) @(negedge clk);

        // R7: stalls on both byte steps
        acc_snap = acc_out;
        expect_add(16'hEDCB);
        push(8'h05);
        for (int g = 0; g < 3; g++) begin
            @(negedge clk);
            check(q_ready && !done && acc_out == acc_snap, "R7 stall lo",
                  {15'h0, q_ready, done, acc_out}, {15'h0, 1'b1, 1'b0, acc_snap});
        end
        push(8'hCB);
        for (int g = 0; g < 5; g++) begin
            @(negedge clk);
            check(q_ready && !done, "R7 stall hi", {30'h0, q_ready, done}, 32'h2);
        end
        push(8'hED);
        repeat (6) @(negedge clk);
        check(acc_out == m_acc, "R7 stalled result", {16'h0, acc_out}, {16'h0, m_acc});

        // R2 / R8 / R6: corner grid, back to back
        have_last = 1'b0;
        chk_int   = 1'b1;
        for (int i = 0; i < 12; i++) begin
            for (int j = 0; j < 12; j++) begin
                push_add(corner[i] - m_acc);
                push_add(corner[j]);
            end
        end
        // pseudo-random stream
        lcg = 32'h1ACE_B00C;
        for (int k = 0; k < 150; k++) begin
            lcg = lcg * 32'd1103515245 + 32'd12345;
            push_add(lcg[31:16]);
        end
        repeat (8) @(negedge clk);
        chk_int = 1'b0;

        check(rd == wr, "R6 all retired", 32'(rd), 32'(wr));
        check(acc_out == m_acc, "R2 final acc", {16'h0, acc_out}, {16'h0, m_acc});

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule